// File: doc/BRIEF.md
# Micro-op Nested Loop Sequencer

The sequencer runs one matrix-multiply or vector-ALU instruction by replaying a window of micro-ops from a local micro-op memory inside a two-level loop. Each micro-op stores a base destination index, a base source index and a base weight index. For every replay the sequencer adds an offset built from the loop counters. A short micro-op list therefore covers a whole two-dimensional iteration space.

An instruction is presented on the field inputs together with a one-cycle `start_i`. The block then reads the micro-op memory once per cycle through a read port with one cycle of latency. It emits one command per cycle carrying the final indices, the mode, the immediate selection and the clear flag. The last command carries a one-cycle `done_o`. The arithmetic datapath and the buffers sit outside this block.

Top module: `uop_seq`

## Requirements
- R1: Commands are issued with the micro-op address as the innermost loop (from `bgn_i` up to `end_i - 1`). The inner iteration counter j (0 to `n_in_i - 1`) is the middle loop and the outer counter i (0 to `n_out_i - 1`) is the outermost loop. Each new address is either the previous address plus one or a wrap back to `bgn_i`.
- R2: `end_i` is one bit wider than `bgn_i`, so `bgn_i = 0`, `end_i = 16` replays all 16 micro-op entries.
- R3: `cmd_dst_o` = (dst base + j*`dst_fi_i` + i*`dst_fo_i`) mod 2^ACC_AW. The micro-op word holds the dst base in bits [ACC_AW-1:0], the src base in the next SRC_AW bits and the wgt base in the top WGT_AW bits.
- R4: `cmd_src_o` = (src base + j*`src_fi_i` + i*`src_fo_i`), taken mod 2^INP_AW in matrix mode (`mode_i` = 0) and mod 2^ACC_AW in ALU mode (`mode_i` = 1).
- R5: In matrix mode `cmd_wgt_o` = (wgt base + j*`wgt_fi_i` + i*`wgt_fo_i`) mod 2^WGT_AW. In ALU mode `cmd_wgt_o` is 0.
- R6: `cmd_imm_sel_o` is 1 only when ALU mode and `use_imm_i` are both set. `cmd_imm_o` then carries `imm_i`; otherwise it is 0.
- R7: `cmd_clr_o` repeats the instruction's clear flag `clr_i` on every command.
- R8: The first command is valid two cycles after the edge that samples `start_i`. Commands follow back-to-back, exactly `n_out_i*n_in_i*(end_i-bgn_i)` of them.
- R9: `done_o` is a single-cycle pulse in the same cycle as the last command.
- R10: If `bgn_i >= end_i`, `n_out_i = 0` or `n_in_i = 0`, no command is issued and `done_o` pulses two cycles after the start edge.
- R11: `busy_o` is high from the start edge until `done_o`. A `start_i` while `busy_o` is high is ignored, and the running command stream is unchanged.
- R12: `uop_req_o` is asserted only with `uop_addr_o` in the range [`bgn_i`, `end_i`) of the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for the instruction on the field inputs |
| mode_i | input | 1 | 0 = matrix multiply, 1 = ALU |
| use_imm_i | input | 1 | ALU second operand from immediate |
| imm_i | input | IMM_W | Signed immediate |
| clr_i | input | 1 | Clear destination instead of accumulate |
| bgn_i | input | UOP_AW | First micro-op address |
| end_i | input | UOP_AW+1 | Micro-op address bound (exclusive) |
| n_out_i | input | ITER_W | Outer iteration count |
| n_in_i | input | ITER_W | Inner iteration count |
| dst_fo_i | input | ACC_AW | Destination outer factor |
| dst_fi_i | input | ACC_AW | Destination inner factor |
| src_fo_i | input | SRC_AW | Source outer factor |
| src_fi_i | input | SRC_AW | Source inner factor |
| wgt_fo_i | input | WGT_AW | Weight outer factor |
| wgt_fi_i | input | WGT_AW | Weight inner factor |
| uop_req_o | output | 1 | Micro-op memory read enable |
| uop_addr_o | output | UOP_AW | Micro-op memory read address |
| uop_data_i | input | UOP_W | Micro-op read data, one cycle after the request |
| busy_o | output | 1 | Instruction in progress |
| cmd_valid_o | output | 1 | Command valid |
| cmd_dst_o | output | ACC_AW | Destination index |
| cmd_src_o | output | SRC_AW | Source index |
| cmd_wgt_o | output | WGT_AW | Weight index |
| cmd_alu_o | output | 1 | Command is an ALU operation |
| cmd_imm_sel_o | output | 1 | Use immediate as second operand |
| cmd_imm_o | output | IMM_W | Immediate value |
| cmd_clr_o | output | 1 | Clear destination |
| done_o | output | 1 | Instruction finished |

## Verification
A read request issued in a loop cycle produces its command two clock edges later: one edge for the memory read and offset capture, one for the index addition into the output registers. So command n of an instruction is due after edge n+2, counted from the edge that sampled `start_i`. `done_o` is due with the final command, or after edge 2 for an empty instruction. `busy_o` is due low from edge max(N,1)+1. The bench counts edges from the start edge, samples every output at the following falling edge, and compares it against the entry its own loop model predicts for that exact cycle.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
  typedef enum logic {
    MODE_GEMM = 1'b0,
    MODE_ALU  = 1'b1
  } seq_mode_e;

  typedef struct packed {
    logic alu;
    logic imm_sel;
    logic clr;
  } cmd_flags_t;
endpackage

// File: rtl/uop_seq_affine.sv
// Running affine offset: outer sum plus inner sum, no multipliers.
module uop_seq_affine #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] f_in_i,
  input  logic [W-1:0] f_out_i,
  input  logic         step_in_i,
  input  logic         wrap_in_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] f_in_q, f_out_q, acc_in_q, acc_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_in_q    <= '0;
      f_out_q   <= '0;
      acc_in_q  <= '0;
      acc_out_q <= '0;
    end else if (load_i) begin
      f_in_q    <= f_in_i;
      f_out_q   <= f_out_i;
      acc_in_q  <= '0;
      acc_out_q <= '0;
    end else if (wrap_in_i) begin
      acc_in_q  <= '0;
      acc_out_q <= acc_out_q + f_out_q;
    end else if (step_in_i) begin
      acc_in_q  <= acc_in_q + f_in_q;
    end
  end

  assign sum_o = acc_out_q + acc_in_q;
endmodule

// File: rtl/uop_seq_loop.sv
module uop_seq_loop #(
  parameter int UOP_AW = 4,
  parameter int ITER_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [UOP_AW-1:0] bgn_i,
  input  logic [UOP_AW:0]   end_i,
  input  logic [ITER_W-1:0] n_out_i,
  input  logic [ITER_W-1:0] n_in_i,
  output logic              run_o,
  output logic [UOP_AW-1:0] addr_o,
  output logic              step_in_o,
  output logic              wrap_in_o,
  output logic              last_o
);
  logic              run_q;
  logic [UOP_AW-1:0] k_q, bgn_q;
  logic [UOP_AW:0]   end_q;
  logic [ITER_W-1:0] j_q, i_q, n_out_q, n_in_q;
  logic              k_end, j_end, i_end;

  assign k_end = ({1'b0, k_q} + 1'b1) == end_q;
  assign j_end = j_q == n_in_q - 1'b1;
  assign i_end = i_q == n_out_q - 1'b1;

  assign step_in_o = run_q & k_end & ~j_end;
  assign wrap_in_o = run_q & k_end & j_end & ~i_end;
  assign last_o    = run_q & k_end & j_end & i_end;
  assign run_o     = run_q;
  assign addr_o    = k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      k_q     <= '0;
      j_q     <= '0;
      i_q     <= '0;
      bgn_q   <= '0;
      end_q   <= '0;
      n_out_q <= '0;
      n_in_q  <= '0;
    end else if (go_i) begin
      run_q   <= 1'b1;
      k_q     <= bgn_i;
      j_q     <= '0;
      i_q     <= '0;
      bgn_q   <= bgn_i;
      end_q   <= end_i;
      n_out_q <= n_out_i;
      n_in_q  <= n_in_i;
    end else if (run_q) begin
      if (k_end) begin
        k_q <= bgn_q;
        if (j_end) begin
          j_q <= '0;
          if (i_end) run_q <= 1'b0;
          else       i_q   <= i_q + 1'b1;
        end else begin
          j_q <= j_q + 1'b1;
        end
      end else begin
        k_q <= k_q + 1'b1;
      end
    end
  end

  p_addr_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (k_q >= bgn_q) && ({1'b0, k_q} < end_q));

  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) && (k_q != bgn_q) |-> k_q == $past(k_q) + 1'b1);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) |-> $stable(end_q) && $stable(bgn_q));
endmodule

// File: rtl/uop_seq_issue.sv
module uop_seq_issue
  import uop_seq_pkg::*;
#(
  parameter int ACC_AW = 7,
  parameter int INP_AW = 6,
  parameter int WGT_AW = 5,
  parameter int IMM_W  = 8,
  parameter int SRC_AW = 7,
  parameter int UOP_W  = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              last_i,
  input  logic              empty_i,
  input  logic [ACC_AW-1:0] off_dst_i,
  input  logic [SRC_AW-1:0] off_src_i,
  input  logic [WGT_AW-1:0] off_wgt_i,
  input  cmd_flags_t        flags_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [UOP_W-1:0]  uop_data_i,
  output logic              pend_o,
  output logic              cmd_valid_o,
  output logic [ACC_AW-1:0] cmd_dst_o,
  output logic [SRC_AW-1:0] cmd_src_o,
  output logic [WGT_AW-1:0] cmd_wgt_o,
  output logic              cmd_alu_o,
  output logic              cmd_imm_sel_o,
  output logic [IMM_W-1:0]  cmd_imm_o,
  output logic              cmd_clr_o,
  output logic              done_o
);
  localparam logic [SRC_AW-1:0] ACC_MASK = SRC_AW'((1 << ACC_AW) - 1);
  localparam logic [SRC_AW-1:0] INP_MASK = SRC_AW'((1 << INP_AW) - 1);

  logic              s1_v, s1_last;
  logic [ACC_AW-1:0] s1_dst;
  logic [SRC_AW-1:0] s1_src;
  logic [WGT_AW-1:0] s1_wgt;

  logic [ACC_AW-1:0] b_dst, n_dst;
  logic [SRC_AW-1:0] b_src, n_src;
  logic [WGT_AW-1:0] b_wgt, n_wgt;

  assign b_dst = uop_data_i[ACC_AW-1:0];
  assign b_src = uop_data_i[ACC_AW +: SRC_AW];
  assign b_wgt = uop_data_i[ACC_AW+SRC_AW +: WGT_AW];

  always_comb begin
    n_dst = b_dst + s1_dst;
    n_src = (b_src + s1_src) & (flags_i.alu ? ACC_MASK : INP_MASK);
    n_wgt = flags_i.alu ? '0 : b_wgt + s1_wgt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s1_dst  <= '0;
      s1_src  <= '0;
      s1_wgt  <= '0;
    end else begin
      s1_v    <= req_i;
      s1_last <= last_i | empty_i;
      s1_dst  <= off_dst_i;
      s1_src  <= off_src_i;
      s1_wgt  <= off_wgt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o   <= 1'b0;
      cmd_dst_o     <= '0;
      cmd_src_o     <= '0;
      cmd_wgt_o     <= '0;
      cmd_alu_o     <= 1'b0;
      cmd_imm_sel_o <= 1'b0;
      cmd_imm_o     <= '0;
      cmd_clr_o     <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      cmd_valid_o   <= s1_v;
      done_o        <= s1_last;
      cmd_dst_o     <= s1_v ? n_dst : '0;
      cmd_src_o     <= s1_v ? n_src : '0;
      cmd_wgt_o     <= s1_v ? n_wgt : '0;
      cmd_alu_o     <= s1_v & flags_i.alu;
      cmd_imm_sel_o <= s1_v & flags_i.imm_sel;
      cmd_imm_o     <= (s1_v & flags_i.imm_sel) ? imm_i : '0;
      cmd_clr_o     <= s1_v & flags_i.clr;
    end
  end

  assign pend_o = s1_v | s1_last;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_alu_no_wgt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_alu_o |-> cmd_wgt_o == '0);
endmodule

// File: rtl/uop_seq.sv
module uop_seq
  import uop_seq_pkg::*;
#(
  parameter int UOP_AW = 4,
  parameter int ACC_AW = 7,
  parameter int INP_AW = 6,
  parameter int WGT_AW = 5,
  parameter int ITER_W = 4,
  parameter int IMM_W  = 8,
  localparam int SRC_AW = (ACC_AW > INP_AW) ? ACC_AW : INP_AW,
  localparam int UOP_W  = ACC_AW + SRC_AW + WGT_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              clr_i,
  input  logic [UOP_AW-1:0] bgn_i,
  input  logic [UOP_AW:0]   end_i,
  input  logic [ITER_W-1:0] n_out_i,
  input  logic [ITER_W-1:0] n_in_i,
  input  logic [ACC_AW-1:0] dst_fo_i,
  input  logic [ACC_AW-1:0] dst_fi_i,
  input  logic [SRC_AW-1:0] src_fo_i,
  input  logic [SRC_AW-1:0] src_fi_i,
  input  logic [WGT_AW-1:0] wgt_fo_i,
  input  logic [WGT_AW-1:0] wgt_fi_i,
  output logic              uop_req_o,
  output logic [UOP_AW-1:0] uop_addr_o,
  input  logic [UOP_W-1:0]  uop_data_i,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output logic [ACC_AW-1:0] cmd_dst_o,
  output logic [SRC_AW-1:0] cmd_src_o,
  output logic [WGT_AW-1:0] cmd_wgt_o,
  output logic              cmd_alu_o,
  output logic              cmd_imm_sel_o,
  output logic [IMM_W-1:0]  cmd_imm_o,
  output logic              cmd_clr_o,
  output logic              done_o
);
  logic              accept, empty, empty_q, pend;
  logic              step_in, wrap_in, last;
  cmd_flags_t        flags_q;
  logic [IMM_W-1:0]  imm_q;
  logic [ACC_AW-1:0] off_dst;
  logic [SRC_AW-1:0] off_src;
  logic [WGT_AW-1:0] off_wgt;

  assign busy_o = uop_req_o | pend | empty_q;
  assign accept = start_i & ~busy_o;
  assign empty  = ({1'b0, bgn_i} >= end_i) | (n_out_i == '0) | (n_in_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      imm_q   <= '0;
      empty_q <= 1'b0;
    end else begin
      empty_q <= accept & empty;
      if (accept) begin
        flags_q.alu     <= (mode_i == MODE_ALU);
        flags_q.imm_sel <= (mode_i == MODE_ALU) & use_imm_i;
        flags_q.clr     <= clr_i;
        imm_q           <= imm_i;
      end
    end
  end

  uop_seq_loop #(.UOP_AW(UOP_AW), .ITER_W(ITER_W)) u_loop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (accept & ~empty),
    .bgn_i     (bgn_i),
    .end_i     (end_i),
    .n_out_i   (n_out_i),
    .n_in_i    (n_in_i),
    .run_o     (uop_req_o),
    .addr_o    (uop_addr_o),
    .step_in_o (step_in),
    .wrap_in_o (wrap_in),
    .last_o    (last)
  );

  uop_seq_affine #(.W(ACC_AW)) u_off_dst (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .f_in_i(dst_fi_i), .f_out_i(dst_fo_i),
    .step_in_i(step_in), .wrap_in_i(wrap_in), .sum_o(off_dst)
  );

  uop_seq_affine #(.W(SRC_AW)) u_off_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .f_in_i(src_fi_i), .f_out_i(src_fo_i),
    .step_in_i(step_in), .wrap_in_i(wrap_in), .sum_o(off_src)
  );

  uop_seq_affine #(.W(WGT_AW)) u_off_wgt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .f_in_i(wgt_fi_i), .f_out_i(wgt_fo_i),
    .step_in_i(step_in), .wrap_in_i(wrap_in), .sum_o(off_wgt)
  );

  uop_seq_issue #(
    .ACC_AW(ACC_AW), .INP_AW(INP_AW), .WGT_AW(WGT_AW),
    .IMM_W(IMM_W), .SRC_AW(SRC_AW), .UOP_W(UOP_W)
  ) u_issue (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (uop_req_o),
    .last_i        (last),
    .empty_i       (empty_q),
    .off_dst_i     (off_dst),
    .off_src_i     (off_src),
    .off_wgt_i     (off_wgt),
    .flags_i       (flags_q),
    .imm_i         (imm_q),
    .uop_data_i    (uop_data_i),
    .pend_o        (pend),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_dst_o     (cmd_dst_o),
    .cmd_src_o     (cmd_src_o),
    .cmd_wgt_o     (cmd_wgt_o),
    .cmd_alu_o     (cmd_alu_o),
    .cmd_imm_sel_o (cmd_imm_sel_o),
    .cmd_imm_o     (cmd_imm_o),
    .cmd_clr_o     (cmd_clr_o),
    .done_o        (done_o)
  );

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(uop_req_o, 2));

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !uop_req_o);
endmodule

// File: tb/sim_uop_seq.sv
`timescale 1ns/1ps
module sim_uop_seq;
  localparam int UOP_AW = 4, ACC_AW = 7, INP_AW = 6, WGT_AW = 5, ITER_W = 4, IMM_W = 8;
  localparam int SRC_AW = 7, UOP_W = 19, DEPTH = 16, MAXN = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start_i = 0, mode_i = 0, use_imm_i = 0, clr_i = 0;
  logic [IMM_W-1:0]  imm_i = '0;
  logic [UOP_AW-1:0] bgn_i = '0;
  logic [UOP_AW:0]   end_i = '0;
  logic [ITER_W-1:0] n_out_i = '0, n_in_i = '0;
  logic [ACC_AW-1:0] dst_fo_i = '0, dst_fi_i = '0;
  logic [SRC_AW-1:0] src_fo_i = '0, src_fi_i = '0;
  logic [WGT_AW-1:0] wgt_fo_i = '0, wgt_fi_i = '0;
  logic              uop_req_o, busy_o, cmd_valid_o, cmd_alu_o, cmd_imm_sel_o, cmd_clr_o, done_o;
  logic [UOP_AW-1:0] uop_addr_o;
  logic [UOP_W-1:0]  uop_data;
  logic [ACC_AW-1:0] cmd_dst_o;
  logic [SRC_AW-1:0] cmd_src_o;
  logic [WGT_AW-1:0] cmd_wgt_o;
  logic [IMM_W-1:0]  cmd_imm_o;

  logic [UOP_W-1:0] umem [DEPTH];
  always_ff @(posedge clk) if (uop_req_o) uop_data <= umem[uop_addr_o];

  uop_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .use_imm_i(use_imm_i), .imm_i(imm_i), .clr_i(clr_i), .bgn_i(bgn_i),
    .end_i(end_i), .n_out_i(n_out_i), .n_in_i(n_in_i),
    .dst_fo_i(dst_fo_i), .dst_fi_i(dst_fi_i), .src_fo_i(src_fo_i),
    .src_fi_i(src_fi_i), .wgt_fo_i(wgt_fo_i), .wgt_fi_i(wgt_fi_i),
    .uop_req_o(uop_req_o), .uop_addr_o(uop_addr_o), .uop_data_i(uop_data),
    .busy_o(busy_o), .cmd_valid_o(cmd_valid_o), .cmd_dst_o(cmd_dst_o),
    .cmd_src_o(cmd_src_o), .cmd_wgt_o(cmd_wgt_o), .cmd_alu_o(cmd_alu_o),
    .cmd_imm_sel_o(cmd_imm_sel_o), .cmd_imm_o(cmd_imm_o),
    .cmd_clr_o(cmd_clr_o), .done_o(done_o)
  );

  int total = 0, bad = 0, cyc = 0;
  int e_dst [MAXN];
  int e_src [MAXN];
  int e_wgt [MAXN];
  int n_exp;
  int cur_bgn = 0, cur_end = 0;
  bit in_run = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // R12: read address stays inside the instruction window
  always @(negedge clk) if (rst_n && in_run && uop_req_o)
    chk(int'(uop_addr_o) >= cur_bgn && int'(uop_addr_o) < cur_end, "R12 addr", int'(uop_addr_o), cur_bgn);

  function automatic int affine(input int b, input int fi, input int fo, input int j, input int i, input int w);
    return (b + j * fi + i * fo) & ((1 << w) - 1);
  endfunction

  task automatic build_expect();
    bit alu = mode_i;
    n_exp = 0;
    if (int'(bgn_i) >= int'(end_i) || n_out_i == 0 || n_in_i == 0) return;
    for (int i = 0; i < int'(n_out_i); i++)
      for (int j = 0; j < int'(n_in_i); j++)
        for (int k = int'(bgn_i); k < int'(end_i); k++) begin
          e_dst[n_exp] = affine(int'(umem[k][6:0]), int'(dst_fi_i), int'(dst_fo_i), j, i, ACC_AW);
          e_src[n_exp] = affine(int'(umem[k][13:7]), int'(src_fi_i), int'(src_fo_i), j, i, alu ? ACC_AW : INP_AW);
          e_wgt[n_exp] = alu ? 0 : affine(int'(umem[k][18:14]), int'(wgt_fi_i), int'(wgt_fo_i), j, i, WGT_AW);
          n_exp++;
        end
  endtask

  task automatic run_case(input bit md, input bit ui, input int imm, input bit cl,
                          input int b, input int e, input int no, input int ni,
                          input int dfo, input int dfi, input int sfo, input int sfi,
                          input int wfo, input int wfi, input bit interfere);
    int n, bl, ei;
    bit ev, ed, eb, sel;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) umem[a] = UOP_W'($urandom);
    mode_i = md; use_imm_i = ui; imm_i = IMM_W'(imm); clr_i = cl;
    bgn_i = UOP_AW'(b); end_i = (UOP_AW+1)'(e); n_out_i = ITER_W'(no); n_in_i = ITER_W'(ni);
    dst_fo_i = ACC_AW'(dfo); dst_fi_i = ACC_AW'(dfi); src_fo_i = SRC_AW'(sfo);
    src_fi_i = SRC_AW'(sfi); wgt_fo_i = WGT_AW'(wfo); wgt_fi_i = WGT_AW'(wfi);
    build_expect();
    cur_bgn = b; cur_end = e; in_run = 1;
    n = n_exp; bl = (n > 0) ? n : 1;
    sel = md & ui;
    ei = sel ? (imm & 255) : 0;
    start_i = 1;
    for (int c = 0; c <= n + 3; c++) begin
      @(negedge clk);
      start_i = interfere && (n > 3) && (c == 1);
      if (start_i) begin
        // R11: conflicting instruction offered while busy
        mode_i = ~md; clr_i = ~cl; bgn_i = '0; end_i = 5'd16; n_out_i = 4'd15;
        dst_fi_i = 7'd1; src_fi_i = 7'd3; wgt_fi_i = 5'd2;
      end
      ev = (n > 0) && c >= 2 && c <= n + 1;
      ed = (n > 0) ? (c == n + 1) : (c == 2);
      eb = c <= bl;
      chk(cmd_valid_o == ev, "R8 valid", int'(cmd_valid_o), int'(ev));
      chk(done_o == ed, (n > 0) ? "R9 done" : "R10 done", int'(done_o), int'(ed));
      chk(busy_o == eb, "R11 busy", int'(busy_o), int'(eb));
      if (ev) begin
        chk(int'(cmd_dst_o) == e_dst[c-2], "R3 dst (R1 order)", int'(cmd_dst_o), e_dst[c-2]);
        chk(int'(cmd_src_o) == e_src[c-2], "R4 src", int'(cmd_src_o), e_src[c-2]);
        chk(int'(cmd_wgt_o) == e_wgt[c-2], "R5 wgt", int'(cmd_wgt_o), e_wgt[c-2]);
        chk(cmd_alu_o == md, "R5 alu flag", int'(cmd_alu_o), int'(md));
        chk(cmd_imm_sel_o == sel && int'(cmd_imm_o) == ei, "R6 imm", int'(cmd_imm_o), ei);
        chk(cmd_clr_o == cl, "R7 clr", int'(cmd_clr_o), int'(cl));
      end
    end
    in_run = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cmd_valid_o && !done_o && !busy_o && !uop_req_o, "reset state", int'(busy_o), 0);

    // R2: full micro-op window
    run_case(0, 0, 0, 0, 0, 16, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run_case(0, 0, 0, 1, 0, 16, 2, 2, 5, 3, 9, 7, 4, 1, 1);
    // R1/R3..R5: small windows with wrapping factors, both modes
    run_case(0, 1, 77, 0, 3, 6, 3, 2, 127, 100, 120, 63, 31, 17, 1);
    run_case(1, 1, -5, 1, 2, 5, 2, 3, 9, 1, 127, 64, 7, 7, 1);
    run_case(1, 0, 12, 0, 7, 8, 4, 4, 2, 1, 3, 1, 1, 1, 0);
    // R10: empty instructions
    run_case(0, 0, 0, 0, 5, 5, 2, 2, 1, 1, 1, 1, 1, 1, 0);
    run_case(1, 0, 0, 0, 9, 4, 2, 2, 1, 1, 1, 1, 1, 1, 0);
    run_case(0, 0, 0, 0, 0, 4, 0, 2, 1, 1, 1, 1, 1, 1, 0);
    run_case(1, 1, 3, 1, 0, 4, 2, 0, 1, 1, 1, 1, 1, 1, 0);
    // random mix
    for (int r = 0; r < 30; r++) begin
      int b = $urandom % 16;
      int e = b + 1 + ($urandom % (16 - b));
      run_case($urandom % 2, $urandom % 2, $urandom % 256, $urandom % 2, b, e,
               1 + $urandom % 4, 1 + $urandom % 4,
               $urandom % 128, $urandom % 128, $urandom % 128, $urandom % 128,
               $urandom % 32, $urandom % 32, $urandom % 2);
    end
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !busy_o, "R11 idle after stream", int'(busy_o), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule